// File: doc/BRIEF.md
# DDR Burst Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM link. It takes one access request at a time and turns it into command-pin encodings on the chip-select, row-strobe, column-strobe and write-enable lines. Each access follows the same sequence. The row is opened, the sequencer waits a fixed row-to-column delay, and then it issues the column read or write with the starting column address. It then times the data phase and closes the row with a precharge.

The burst length, burst ordering and CAS latency come from a small mode register, which is loaded through a dedicated port. During the data phase the block raises a read-valid strobe or a write-data-request strobe. Two beats move per clock, so the strobe stays high for half the burst length. The column address of both beats in each clock is also shown, so the datapath knows which words are moving. Read data arrives a CAS latency after the read command. Write data is requested in the clock right after the write command.

Top module: `ddr_burst_seq`

## Requirements
- R1: After reset, and in every cycle with no access in progress, the command pins carry no-operation {cs_n,ras_n,cas_n,we_n} = 0111, `busy` is low and `req_ready` is high.
- R2: A request taken on a clock edge (req_valid and req_ready high) produces an activate {0,0,1,1} in the next cycle, with the request bank on `cmd_ba` and the row on `cmd_addr`. `req_ready` stays low while `busy` is high.
- R3: The column command comes exactly TRCD cycles after the activate. A read is {0,1,0,1} and a write is {0,1,0,0}. In both cases `cmd_addr` carries the start column, zero-extended.
- R4: For a read, `rd_valid` rises CL cycles after the read command and stays high for burst-length/2 consecutive cycles. CL is 2 or 3.
- R5: For a write, `wr_req` rises in the cycle after the write command and stays high for burst-length/2 consecutive cycles. There is no added latency.
- R6: Sequential ordering: beat i has column (start with its low log2(BL) bits replaced by (start+i) mod BL). Beat i is on `beat_col_even` for even i and on `beat_col_odd` for odd i, with beats 2k and 2k+1 in the k-th data cycle.
- R7: Interleaved ordering: beat i keeps the upper column bits, and its low log2(BL) bits are the start's low bits XOR i.
- R8: Mode register fields are a length code (1, 2 or 3 giving 2, 4 or 8 beats), an interleave bit and a CL3 bit (1 gives CL 3, 0 gives CL 2). The reset values are code 2, sequential and CL 3.
- R9: A mode load takes effect only when `busy` is low, and a length code of 0 is ignored entirely. A load on the same edge as an accepted request applies to that request.
- R10: In the cycle after the last data cycle, a precharge {0,0,1,0} is issued with the bank on `cmd_ba`. `busy` is high from the activate through the precharge and falls in the following cycle.
- R11: `rd_valid` and `wr_req` are never high together, and no command appears outside the cycles named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load the mode register |
| mode_len_code | input | 2 | Burst length code: 1, 2 or 3 for 2, 4 or 8 beats |
| mode_interleave | input | 1 | 1 selects interleaved beat order |
| mode_cl3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Start column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address to memory |
| cmd_addr | output | ROW_W | Row or column address to memory |
| busy | output | 1 | An access is in progress |
| rd_valid | output | 1 | Read beat pair expected this cycle |
| wr_req | output | 1 | Write beat pair must be driven this cycle |
| beat_col_even | output | COL_W | Column of the even beat this cycle |
| beat_col_odd | output | COL_W | Column of the odd beat this cycle |

## Verification
The hardest cases to reach from the ports are a mode load that arrives while a burst is in flight, and an 8-beat interleaved burst that starts near the top of its aligned column block. The stimulus pulses the mode port with a different length code in the middle of a burst. It then checks that the next burst still uses the old length. Directed start columns with all low bits set are run under every length and ordering. Seeded random requests and mode codes, including the ignored code 0, cover the remaining mix of latency, length and direction.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP,
    ST_COL,
    ST_XFER,
    ST_CLOSE
  } st_t;

  typedef struct packed {
    logic [1:0] len_code;
    logic       il;
    logic       cl3;
  } mode_t;

  // number of beats for a stored length code
  function automatic logic [3:0] beats_of(logic [1:0] code);
    case (code)
      2'd1:    return 4'd2;
      2'd3:    return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

  // cycles in the transfer state before the first data cycle
  function automatic logic [3:0] lead_of(logic is_rd, logic cl3);
    if (!is_rd) return 4'd0;
    return cl3 ? 4'd2 : 4'd1;
  endfunction

  // low three column bits of beat idx inside its aligned block
  function automatic logic [2:0] wrap_idx(logic [2:0] start, logic [2:0] idx,
                                          logic [3:0] beats, logic il);
    logic [2:0] mask;
    logic [2:0] off;
    mask = 3'(beats - 4'd1);
    off  = il ? (start ^ idx) : (start + idx);
    return (start & ~mask) | (off & mask);
  endfunction

endpackage

// File: rtl/ddr_seq_mode.sv
module ddr_seq_mode
  import ddr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       idle,
  input  logic [1:0] len_code,
  input  logic       il,
  input  logic       cl3,
  output mode_t      mode,
  output logic       load_taken
);

  assign load_taken = load && idle && (len_code != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode.len_code <= 2'd2;
      mode.il       <= 1'b0;
      mode.cl3      <= 1'b1;
    end else if (load_taken) begin
      mode.len_code <= len_code;
      mode.il       <= il;
      mode.cl3      <= cl3;
    end
  end

endmodule

// File: rtl/ddr_seq_fsm.sv
module ddr_seq_fsm
  import ddr_seq_pkg::*;
#(
  parameter int TRCD   = 3,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  mode_t             mode,
  output st_t               st,
  output logic              req_taken,
  output logic              wr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic              xfer_on,
  output logic [1:0]        pair_idx
);

  localparam int         GAP_END_I = (TRCD > 1) ? TRCD - 2 : 0;
  localparam logic [3:0] GAP_END   = 4'(GAP_END_I);

  logic [3:0] cnt;
  logic [3:0] lead;
  logic [3:0] half;
  logic [3:0] last_cnt;
  logic [3:0] rel;

  assign req_taken = (st == ST_IDLE) && req_valid;
  assign lead      = lead_of(!wr_q, mode.cl3);
  assign half      = beats_of(mode.len_code) >> 1;
  assign last_cnt  = lead + half - 4'd1;
  assign rel       = cnt - lead;
  assign xfer_on   = (st == ST_XFER) && (cnt >= lead);
  assign pair_idx  = xfer_on ? rel[1:0] : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= 4'd0;
      wr_q   <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_taken) begin
            st     <= ST_ACT;
            wr_q   <= req_write;
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
          end
        end
        ST_ACT: begin
          cnt <= 4'd0;
          st  <= (TRCD > 1) ? ST_GAP : ST_COL;
        end
        ST_GAP: begin
          if (cnt == GAP_END) begin
            st  <= ST_COL;
            cnt <= 4'd0;
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
        ST_COL: begin
          st  <= ST_XFER;
          cnt <= 4'd0;
        end
        ST_XFER: begin
          if (cnt == last_cnt) begin
            st  <= ST_CLOSE;
            cnt <= 4'd0;
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
        ST_CLOSE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ddr_seq_beat.sv
module ddr_seq_beat
  import ddr_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       pair_idx,
  input  mode_t            mode,
  output logic [COL_W-1:0] col_even,
  output logic [COL_W-1:0] col_odd
);

  logic [1:0][COL_W-1:0] cols;
  logic [3:0]            beats;

  assign beats = beats_of(mode.len_code);

  for (genvar g = 0; g < 2; g++) begin : g_beat
    logic [2:0] idx;
    assign idx     = {pair_idx, 1'(g)};
    assign cols[g] = {start_col[COL_W-1:3],
                      wrap_idx(start_col[2:0], idx, beats, mode.il)};
  end

  assign col_even = cols[0];
  assign col_odd  = cols[1];

endmodule

// File: rtl/ddr_seq_cmd.sv
module ddr_seq_cmd
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8
) (
  input  st_t               st,
  input  logic              wr_q,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [ROW_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  output cmd_t              cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr
);

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    case (st)
      ST_ACT: begin
        cmd  = CMD_ACT;
        ba   = bank_q;
        addr = row_q;
      end
      ST_COL: begin
        cmd  = wr_q ? CMD_WR : CMD_RD;
        ba   = bank_q;
        addr = ROW_W'(col_q);
      end
      ST_CLOSE: begin
        cmd = CMD_PRE;
        ba  = bank_q;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int TRCD   = 3,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [1:0]        mode_len_code,
  input  logic              mode_interleave,
  input  logic              mode_cl3,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic              busy,
  output logic              rd_valid,
  output logic              wr_req,
  output logic [COL_W-1:0]  beat_col_even,
  output logic [COL_W-1:0]  beat_col_odd
);

  mode_t             mode_q;
  logic              mode_taken;
  logic [3:0]        mode_beats;
  st_t               st;
  logic              req_taken;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              xfer_on;
  logic [1:0]        pair_idx;
  cmd_t              cmd;

  assign req_ready  = (st == ST_IDLE);
  assign busy       = !req_ready;
  assign mode_beats = beats_of(mode_q.len_code);

  ddr_seq_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (mode_load),
    .idle       (req_ready),
    .len_code   (mode_len_code),
    .il         (mode_interleave),
    .cl3        (mode_cl3),
    .mode       (mode_q),
    .load_taken (mode_taken)
  );

  ddr_seq_fsm #(
    .TRCD(TRCD), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .mode      (mode_q),
    .st        (st),
    .req_taken (req_taken),
    .wr_q      (wr_q),
    .bank_q    (bank_q),
    .row_q     (row_q),
    .col_q     (col_q),
    .xfer_on   (xfer_on),
    .pair_idx  (pair_idx)
  );

  ddr_seq_beat #(.COL_W(COL_W)) u_beat (
    .start_col (col_q),
    .pair_idx  (pair_idx),
    .mode      (mode_q),
    .col_even  (beat_col_even),
    .col_odd   (beat_col_odd)
  );

  ddr_seq_cmd #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_cmd (
    .st     (st),
    .wr_q   (wr_q),
    .bank_q (bank_q),
    .row_q  (row_q),
    .col_q  (col_q),
    .cmd    (cmd),
    .ba     (cmd_ba),
    .addr   (cmd_addr)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;
  assign rd_valid = xfer_on && !wr_q;
  assign wr_req   = xfer_on && wr_q;

endmodule

// File: rtl/ddr_burst_seq_chk.sv
module ddr_burst_seq_chk #(
  parameter int TRCD = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       busy,
  input logic [3:0] cmd,
  input logic       rd_valid,
  input logic       wr_req,
  input logic [3:0] beats,
  input logic       cl3,
  input logic       mode_taken,
  input logic       req_taken
);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic [3:0] since_act;
  logic [3:0] data_cycles;
  logic       data_on;

  assign data_on = rd_valid || wr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act   <= 4'd0;
      data_cycles <= 4'd0;
    end else begin
      if (cmd == C_ACT)            since_act <= 4'd1;
      else if (since_act != 4'hF)  since_act <= since_act + 4'd1;
      if (cmd == C_PRE)            data_cycles <= 4'd0;
      else if (data_on)            data_cycles <= data_cycles + 4'd1;
    end
  end

  a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd == C_NOP && req_ready));

  a_r2_act_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == C_ACT));

  a_r2_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> (since_act == 4'(TRCD)));

  a_r4_cl3_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && cl3) |-> ##3 rd_valid);

  a_r4_cl2_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && !cl3) |-> ##2 rd_valid);

  a_r5_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_WR) |=> wr_req);

  a_r9_no_mode_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mode_taken |-> (!busy || req_taken));

  a_r10_pre_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_on) |-> (cmd == C_PRE));

  a_r10_pair_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (data_cycles == (beats >> 1)));

  a_r11_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_req));

endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(.TRCD(TRCD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .cmd        ({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}),
  .rd_valid   (rd_valid),
  .wr_req     (wr_req),
  .beats      (mode_beats),
  .cl3        (mode_q.cl3),
  .mode_taken (mode_taken),
  .req_taken  (req_taken)
);

// File: tb/ddr_burst_seq_test.sv
module ddr_burst_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TRCD   = 3;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_load = 1'b0;
  logic [1:0]        mode_len_code = 2'd0;
  logic              mode_interleave = 1'b0;
  logic              mode_cl3 = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [BANK_W-1:0] cmd_ba;
  logic [ROW_W-1:0]  cmd_addr;
  logic              busy, rd_valid, wr_req;
  logic [COL_W-1:0]  beat_col_even, beat_col_odd;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench copy of mode register
  int m_code = 2;
  int m_il   = 0;
  int m_cl3  = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_burst_seq #(
    .TRCD(TRCD), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) uut (.*);

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pins();
    return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  endfunction

  function automatic int exp_col(int start, int i, int beats, int il);
    int base, low;
    low  = start % beats;
    base = start - low;
    if (il != 0) return base + (low ^ i);
    return base + ((low + i) % beats);
  endfunction

  task automatic set_mode(int code, int il, int cl3);
    @(negedge clk);
    mode_load = 1'b1;
    mode_len_code = 2'(code);
    mode_interleave = 1'(il);
    mode_cl3 = 1'(cl3);
    @(negedge clk);
    mode_load = 1'b0;
    if (code != 0 && !busy) begin
      m_code = code; m_il = il; m_cl3 = cl3;
    end
  endtask

  task automatic do_req(int wr, int bank, int row, int col, int poke);
    int beats, half, col_at, d0, pre;
    @(negedge clk);
    chk("R1 ready idle", int'(req_ready), 1);
    chk("R1 nop idle", pins(), 'b0111);
    req_valid = 1'b1;
    req_write = 1'(wr);
    req_bank = BANK_W'(bank);
    req_row = ROW_W'(row);
    req_col = COL_W'(col);
    beats  = 1 << m_code;
    half   = beats / 2;
    col_at = 1 + TRCD;
    d0     = col_at + ((wr != 0) ? 1 : (m_cl3 != 0 ? 3 : 2));
    pre    = d0 + half;
    @(posedge clk);
    for (int n = 1; n <= pre + 1; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (poke != 0 && n == 2) begin
        mode_load = 1'b1;
        mode_len_code = (m_code == 3) ? 2'd1 : 2'd3;
        mode_interleave = 1'(~m_il);
        mode_cl3 = 1'(~m_cl3);
      end
      if (n == 3) mode_load = 1'b0;
      if (n == 1) begin
        chk("R2 act", pins(), 'b0011);
        chk("R2 act bank", int'(cmd_ba), bank);
        chk("R2 act row", int'(cmd_addr), row);
      end else if (n == col_at) begin
        chk("R3 col cmd", pins(), (wr != 0) ? 'b0100 : 'b0101);
        chk("R3 col addr", int'(cmd_addr), col);
        chk("R3 col bank", int'(cmd_ba), bank);
      end else if (n == pre) begin
        chk("R10 pre", pins(), 'b0010);
        chk("R10 pre bank", int'(cmd_ba), bank);
      end else begin
        chk("R11 nop", pins(), 'b0111);
      end
      if (n <= pre) begin
        chk("R10 busy", int'(busy), 1);
        chk("R2 ready low", int'(req_ready), 0);
      end else begin
        chk("R10 busy drop", int'(busy), 0);
        chk("R1 ready back", int'(req_ready), 1);
      end
      if (n >= d0 && n < pre) begin
        chk((wr != 0) ? "R5 wr_req" : "R4 rd_valid",
            int'((wr != 0) ? wr_req : rd_valid), 1);
        chk("R11 other dir", int'((wr != 0) ? rd_valid : wr_req), 0);
        chk((m_il != 0) ? "R7 even col" : "R6 even col", int'(beat_col_even),
            exp_col(col, 2*(n-d0), beats, m_il));
        chk((m_il != 0) ? "R7 odd col" : "R6 odd col", int'(beat_col_odd),
            exp_col(col, 2*(n-d0)+1, beats, m_il));
      end else begin
        chk("R4 R5 window", int'(rd_valid | wr_req), 0);
      end
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset nop", pins(), 'b0111);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset ready", int'(req_ready), 1);
    // R8 reset mode: 4 beats sequential CL3
    do_req(0, 1, 12'h5A5, 8'h13, 0);
    do_req(1, 2, 12'h0F0, 8'h22, 0);
    // R8 every length and order, start at top of block
    for (int code = 1; code <= 3; code++) begin
      for (int il = 0; il < 2; il++) begin
        set_mode(code, il, code & 1);
        do_req(0, 3, 12'h123, 8'hA7, 0);
        do_req(1, 0, 12'h321, 8'h3F, 0);
      end
    end
    // R9 code 0 ignored
    set_mode(2, 0, 0);
    set_mode(0, 1, 1);
    do_req(0, 1, 12'h777, 8'h05, 0);
    // R9 load while busy ignored
    do_req(1, 2, 12'h111, 8'h06, 1);
    do_req(0, 2, 12'h222, 8'h07, 0);
    // random mix
    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(0, 2) == 0)
        set_mode(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 1)));
      do_req(int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 4095)), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 3) == 0));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule